// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block keeps the program order of an out-of-order core that executes speculatively. Every instruction leaving dispatch claims one slot in a circular buffer. The slot number goes back to dispatch as the rename tag for that instruction. Functional units later deliver results by tag, in any order. A separate lookup port lets dispatch read a result that is finished but not yet retired, so a consumer does not have to wait for the producer to commit.

Retirement happens only at the oldest slot, and at most once per cycle. It is the only path that can write the architectural register file or release a store to memory. Each slot records what kind of instruction it holds, and that kind decides what happens at commit:
- A register instruction writes its destination register.
- A store instruction releases its value on the store port.
- A branch compares the direction it resolved to with the direction that was predicted.

When a branch turns out to be mispredicted, the buffer discards every younger slot, raises a redirect, and restarts allocation directly behind that branch.

Top module: `spec_rob`

## Requirements
- R1: After reset the buffer is empty. `alloc_ready` is 1, `lk_ready` is 0 for every tag, and `rf_we`, `st_valid` and `redirect` are 0.
- R2: Accepted allocations (`alloc_valid` and `alloc_ready` both high at a rising edge) receive tags 0, 1, 2, ... in order, wrapping from DEPTH-1 back to 0. `alloc_tag` shows the tag the next allocation will receive.
- R3: While DEPTH instructions are in flight, `alloc_ready` is 0, and a request made then is not recorded.
- R4: A writeback to an occupied slot marks it ready and stores its value. From the next cycle on, a lookup of that tag returns `lk_ready`=1 and that value. The lookup itself is combinational.
- R5: Retirement follows allocation order, with at most one slot per cycle. The oldest slot retires at the first rising edge at which it is ready, and its retire outputs are high for the one cycle after that edge. A slot that is not ready blocks all younger slots.
- R6: Kind code 0 (register) retires with `rf_we`=1, `rf_addr` equal to its destination and `rf_data` equal to its result. The store port stays idle.
- R7: Kind code 1 (store) retires with `st_valid`=1 and `st_data` equal to its result. `rf_we` stays 0.
- R8: Kind code 2 (branch) takes its resolved direction from `wb_taken`. If that matches the predicted direction given at allocation, the branch retires with no register write, no store and no redirect.
- R9: A branch whose resolved direction differs from its prediction retires with `redirect`=1 and `redirect_taken` set to the resolved direction. Every younger slot is discarded: it never retires and looks up as not ready. The next allocation receives the tag just after the branch.
- R10: A writeback to a slot that is not occupied, including one that was just discarded, is ignored. That tag still looks up as not ready, and it is not ready once it is allocated again.
- R11: In the cycle a mispredicted branch sits ready at the head, `alloc_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Dispatch requests a slot |
| alloc_kind | input | 2 | 0 register, 1 store, 2 branch |
| alloc_dest | input | REG_W | Destination register number |
| alloc_pred_taken | input | 1 | Predicted branch direction |
| alloc_ready | output | 1 | A slot can be accepted this cycle |
| alloc_tag | output | TAG_W | Tag given to this cycle's allocation |
| wb_valid | input | 1 | Result delivery strobe |
| wb_tag | input | TAG_W | Slot being completed |
| wb_value | input | DATA_W | Result value |
| wb_taken | input | 1 | Resolved branch direction |
| lk_tag | input | TAG_W | Tag to look up |
| lk_ready | output | 1 | The looked-up slot holds a valid result |
| lk_value | output | DATA_W | Result of the looked-up slot |
| rf_we | output | 1 | Register file write strobe |
| rf_addr | output | REG_W | Register being written |
| rf_data | output | DATA_W | Value being written |
| st_valid | output | 1 | Store release strobe |
| st_data | output | DATA_W | Store value |
| redirect | output | 1 | A mispredicted branch retired |
| redirect_taken | output | 1 | Correct direction for the fetch redirect |

## Verification
The hardest case to reach from the ports is a flush that overlaps other activity. The mispredicted branch must reach the head while younger slots are in flight, some finished and some not. In that same cycle, dispatch is still requesting a slot and a unit is delivering into a younger slot. The stimulus drains the buffer first, so that a chosen branch becomes the oldest. It then allocates behind the branch and completes one younger slot. It delivers the opposite direction to the branch, and holds an allocation and a late writeback exactly in the flush cycle. After that it writes to a discarded tag and looks that tag up. A long seeded random phase then mixes all kinds, direction mismatches and stray writebacks. A behavioural model checks every cycle of it.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    KIND_REG    = 2'd0,
    KIND_STORE  = 2'd1,
    KIND_BRANCH = 2'd2,
    KIND_NONE   = 2'd3
  } rob_kind_e;
endpackage

// File: rtl/rob_pointers.sv
// Head, tail and occupancy of the circular buffer.
module rob_pointers #(
  parameter int DEPTH = 8,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  output logic [TAG_W-1:0] head,
  output logic [TAG_W-1:0] tail,
  output logic [CNT_W-1:0] count,
  output logic             full
);
  function automatic logic [TAG_W-1:0] step(input logic [TAG_W-1:0] p);
    return (p == TAG_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full = (count == CNT_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else if (flush) begin
      // the retiring branch leaves, everything behind it is dropped
      head  <= step(head);
      tail  <= step(head);
      count <= '0;
    end else begin
      if (pop)  head <= step(head);
      if (push) tail <= step(tail);
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end
endmodule

// File: rtl/rob_entries.sv
// Per-slot storage: flags with reset, payload arrays without reset.
module rob_entries #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int REG_W  = 5,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_en,
  input  logic [TAG_W-1:0]  alloc_idx,
  input  logic [1:0]        alloc_kind,
  input  logic [REG_W-1:0]  alloc_dest,
  input  logic              alloc_pred,
  input  logic              wb_en,
  input  logic [TAG_W-1:0]  wb_idx,
  input  logic [DATA_W-1:0] wb_value,
  input  logic              wb_taken,
  input  logic              clr_en,
  input  logic [TAG_W-1:0]  clr_idx,
  input  logic              flush_all,
  input  logic [TAG_W-1:0]  head_idx,
  input  logic [TAG_W-1:0]  lk_idx,
  output logic              head_valid,
  output logic              head_ready,
  output logic [1:0]        head_kind,
  output logic [REG_W-1:0]  head_dest,
  output logic [DATA_W-1:0] head_value,
  output logic              head_pred,
  output logic              head_taken,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_value
);
  logic [DEPTH-1:0]  valid_q, ready_q, pred_q, taken_q;
  logic [1:0]        kind_mem  [DEPTH];
  logic [REG_W-1:0]  dest_mem  [DEPTH];
  logic [DATA_W-1:0] value_mem [DEPTH];

  logic wb_hit;
  assign wb_hit = wb_en && valid_q[wb_idx];

  // payload: plain write-enabled arrays, no reset
  always_ff @(posedge clk) begin
    if (wb_hit) value_mem[wb_idx] <= wb_value;
    if (alloc_en) begin
      kind_mem[alloc_idx] <= alloc_kind;
      dest_mem[alloc_idx] <= alloc_dest;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      ready_q <= '0;
      pred_q  <= '0;
      taken_q <= '0;
    end else begin
      if (wb_hit) begin
        ready_q[wb_idx] <= 1'b1;
        taken_q[wb_idx] <= wb_taken;
      end
      if (clr_en)    valid_q[clr_idx] <= 1'b0;
      if (flush_all) valid_q <= '0;
      if (alloc_en) begin
        valid_q[alloc_idx] <= 1'b1;
        ready_q[alloc_idx] <= 1'b0;
        pred_q[alloc_idx]  <= alloc_pred;
      end
    end
  end

  assign head_valid = valid_q[head_idx];
  assign head_ready = ready_q[head_idx];
  assign head_kind  = kind_mem[head_idx];
  assign head_dest  = dest_mem[head_idx];
  assign head_value = value_mem[head_idx];
  assign head_pred  = pred_q[head_idx];
  assign head_taken = taken_q[head_idx];
  assign lk_hit     = valid_q[lk_idx] && ready_q[lk_idx];
  assign lk_value   = value_mem[lk_idx];
endmodule

// File: rtl/rob_retire.sv
// Decides the commit action of the head slot and registers it.
module rob_retire
  import rob_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic [1:0]        kind,
  input  logic [REG_W-1:0]  dest,
  input  logic [DATA_W-1:0] value,
  input  logic              pred,
  input  logic              taken,
  output logic              mispredict,
  output logic              rf_we,
  output logic [REG_W-1:0]  rf_addr,
  output logic [DATA_W-1:0] rf_data,
  output logic              st_valid,
  output logic [DATA_W-1:0] st_data,
  output logic              redirect,
  output logic              redirect_taken
);
  rob_kind_e k;
  assign k = rob_kind_e'(kind);
  assign mispredict = fire && (k == KIND_BRANCH) && (taken != pred);

  always_ff @(posedge clk) begin
    if (rst) begin
      rf_we          <= 1'b0;
      rf_addr        <= '0;
      rf_data        <= '0;
      st_valid       <= 1'b0;
      st_data        <= '0;
      redirect       <= 1'b0;
      redirect_taken <= 1'b0;
    end else begin
      rf_we          <= fire && (k == KIND_REG);
      rf_addr        <= dest;
      rf_data        <= value;
      st_valid       <= fire && (k == KIND_STORE);
      st_data        <= value;
      redirect       <= mispredict;
      redirect_taken <= taken;
    end
  end
endmodule

// File: rtl/spec_rob.sv
module spec_rob #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int REG_W  = 5,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_valid,
  input  logic [1:0]        alloc_kind,
  input  logic [REG_W-1:0]  alloc_dest,
  input  logic              alloc_pred_taken,
  output logic              alloc_ready,
  output logic [TAG_W-1:0]  alloc_tag,
  input  logic              wb_valid,
  input  logic [TAG_W-1:0]  wb_tag,
  input  logic [DATA_W-1:0] wb_value,
  input  logic              wb_taken,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              lk_ready,
  output logic [DATA_W-1:0] lk_value,
  output logic              rf_we,
  output logic [REG_W-1:0]  rf_addr,
  output logic [DATA_W-1:0] rf_data,
  output logic              st_valid,
  output logic [DATA_W-1:0] st_data,
  output logic              redirect,
  output logic              redirect_taken
);
  logic [TAG_W-1:0]  head_q, tail_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              full_w, push, fire, flush;
  logic              h_valid, h_ready, h_pred, h_taken;
  logic [1:0]        h_kind;
  logic [REG_W-1:0]  h_dest;
  logic [DATA_W-1:0] h_value;

  assign fire        = h_valid && h_ready;
  assign alloc_ready = !full_w && !flush;
  assign push        = alloc_valid && alloc_ready;
  assign alloc_tag   = tail_q;

  rob_pointers #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst(rst), .push(push), .pop(fire), .flush(flush),
    .head(head_q), .tail(tail_q), .count(cnt_q), .full(full_w)
  );

  rob_entries #(.DEPTH(DEPTH), .DATA_W(DATA_W), .REG_W(REG_W)) u_ent (
    .clk(clk), .rst(rst),
    .alloc_en(push), .alloc_idx(tail_q), .alloc_kind(alloc_kind),
    .alloc_dest(alloc_dest), .alloc_pred(alloc_pred_taken),
    .wb_en(wb_valid), .wb_idx(wb_tag), .wb_value(wb_value), .wb_taken(wb_taken),
    .clr_en(fire), .clr_idx(head_q), .flush_all(flush),
    .head_idx(head_q), .lk_idx(lk_tag),
    .head_valid(h_valid), .head_ready(h_ready), .head_kind(h_kind),
    .head_dest(h_dest), .head_value(h_value), .head_pred(h_pred),
    .head_taken(h_taken), .lk_hit(lk_ready), .lk_value(lk_value)
  );

  rob_retire #(.DATA_W(DATA_W), .REG_W(REG_W)) u_ret (
    .clk(clk), .rst(rst), .fire(fire), .kind(h_kind), .dest(h_dest),
    .value(h_value), .pred(h_pred), .taken(h_taken), .mispredict(flush),
    .rf_we(rf_we), .rf_addr(rf_addr), .rf_data(rf_data),
    .st_valid(st_valid), .st_data(st_data),
    .redirect(redirect), .redirect_taken(redirect_taken)
  );
endmodule

// File: rtl/spec_rob_chk.sv
module spec_rob_chk #(
  parameter int DEPTH = 8,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             alloc_valid,
  input logic             alloc_ready,
  input logic [TAG_W-1:0] tail,
  input logic [CNT_W-1:0] count,
  input logic             rf_we,
  input logic             st_valid,
  input logic             redirect
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rf_we && !st_valid && !redirect));

  // R2
  tag_sequence_chk: assert property (@(posedge clk) disable iff (rst)
    (alloc_valid && alloc_ready) |=>
      (tail == (($past(tail) == TAG_W'(DEPTH - 1)) ? '0 : $past(tail) + 1'b1)));

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (count == CNT_W'(DEPTH)) |-> !alloc_ready);

  // R5
  single_retire_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rf_we, st_valid, redirect}));

  // R9
  flush_empties_chk: assert property (@(posedge clk) disable iff (rst)
    redirect |-> (count == '0));
endmodule

bind spec_rob spec_rob_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
  .tail(tail_q), .count(cnt_q), .rf_we(rf_we), .st_valid(st_valid),
  .redirect(redirect)
);

// File: tb/spec_rob_bench.sv
`timescale 1ns/1ps
module spec_rob_bench;
  localparam int N = 8;
  logic clk = 0, rst = 1;
  logic alloc_valid = 0, alloc_pred_taken = 0, wb_valid = 0, wb_taken = 0;
  logic [1:0] alloc_kind = 0;
  logic [4:0] alloc_dest = 0;
  logic [2:0] wb_tag = 0, lk_tag = 0, alloc_tag;
  logic [31:0] wb_value = 0, lk_value, rf_data, st_data;
  logic alloc_ready, lk_ready, rf_we, st_valid, redirect, redirect_taken;
  logic [4:0] rf_addr;

  spec_rob u_spec_rob (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit m_valid[N], m_ready[N], m_pred[N], m_taken[N];
  int m_kind[N], m_dest[N];
  logic [31:0] m_val[N];
  int q[$];
  int m_next = 0;
  bit e_rf_we = 0, e_st = 0, e_red = 0, e_red_tk = 0;
  int e_addr = 0;
  logic [31:0] e_data = 0;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one clock cycle; entered and left at a falling edge
  task automatic step(bit av, int ak, int ad, bit ap,
                      bit wv, int wt, logic [31:0] wd, bit wk, int lt);
    bit flush_now, commit, exp_ar;
    int h;
    alloc_valid = av; alloc_kind = 2'(ak); alloc_dest = 5'(ad); alloc_pred_taken = ap;
    wb_valid = wv; wb_tag = 3'(wt); wb_value = wd; wb_taken = wk; lk_tag = 3'(lt);
    #1;
    h = (q.size() > 0) ? q[0] : 0;
    commit = (q.size() > 0) && m_ready[h];
    flush_now = commit && m_kind[h] == 2 && m_taken[h] != m_pred[h];
    exp_ar = (q.size() < N) && !flush_now;
    chk(alloc_ready == exp_ar, flush_now ? "R11" : "R3", "alloc_ready", 32'(alloc_ready), 32'(exp_ar));
    if (exp_ar) chk(alloc_tag == 3'(m_next), "R2", "alloc_tag", 32'(alloc_tag), 32'(m_next));
    chk(lk_ready == (m_valid[lt] && m_ready[lt]), "R10", "lk_ready", 32'(lk_ready),
        32'(m_valid[lt] && m_ready[lt]));
    if (m_valid[lt] && m_ready[lt]) chk(lk_value == m_val[lt], "R4", "lk_value", lk_value, m_val[lt]);
    chk(rf_we == e_rf_we, "R6", "rf_we", 32'(rf_we), 32'(e_rf_we));
    if (e_rf_we) begin
      chk(rf_addr == 5'(e_addr), "R6", "rf_addr", 32'(rf_addr), 32'(e_addr));
      chk(rf_data == e_data, "R5", "rf_data", rf_data, e_data);
    end
    chk(st_valid == e_st, "R7", "st_valid", 32'(st_valid), 32'(e_st));
    if (e_st) chk(st_data == e_data, "R7", "st_data", st_data, e_data);
    chk(redirect == e_red, "R9", "redirect", 32'(redirect), 32'(e_red));
    if (e_red) chk(redirect_taken == e_red_tk, "R9", "redirect_taken", 32'(redirect_taken), 32'(e_red_tk));
    // model update for this edge
    e_rf_we = commit && m_kind[h] == 0;
    e_st    = commit && m_kind[h] == 1;
    e_red   = flush_now;
    e_red_tk = m_taken[h];
    e_addr  = m_dest[h];
    e_data  = m_val[h];
    if (wv && m_valid[wt]) begin
      m_ready[wt] = 1; m_val[wt] = wd; m_taken[wt] = wk;
    end
    if (commit) begin
      m_valid[h] = 0;
      void'(q.pop_front());
    end
    if (flush_now) begin
      foreach (q[i]) m_valid[q[i]] = 0;
      q.delete();
      m_next = (h + 1) % N;
    end
    if (av && exp_ar) begin
      m_valid[m_next] = 1; m_ready[m_next] = 0; m_kind[m_next] = ak;
      m_dest[m_next] = ad; m_pred[m_next] = ap;
      q.push_back(m_next);
      m_next = (m_next + 1) % N;
    end
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle(int lt);          step(0, 0, 0, 0, 0, 0, 0, 0, lt); endtask
  task automatic al(int k, int d, bit p); step(1, k, d, p, 0, 0, 0, 0, 0); endtask
  task automatic wb(int t, logic [31:0] v, bit tk, int lt); step(0, 0, 0, 0, 1, t, v, tk, lt); endtask

  bit done = 0;
  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int b;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    #1;
    chk(alloc_ready == 1, "R1", "alloc_ready", 32'(alloc_ready), 1);
    chk({rf_we, st_valid, redirect} == 0, "R1", "retire outputs", 32'({rf_we, st_valid, redirect}), 0);
    chk(lk_ready == 0, "R1", "lk_ready", 32'(lk_ready), 0);
    @(negedge clk);
    // R4/R5/R6: out-of-order completion, in-order retirement
    al(0, 3, 0); al(0, 4, 0); al(0, 5, 0);
    wb(2, 32'hC2, 0, 2); idle(2); wb(0, 32'hA0, 0, 2); wb(1, 32'hB1, 0, 1);
    repeat (4) idle(0);
    // R3: fill up, then a refused request
    for (int i = 0; i < N; i++) al(0, i + 8, 0);
    al(1, 1, 0); al(0, 2, 0);
    for (int i = 0; i < N; i++) wb((3 + N - 1 - i) % N, 32'h100 + i, 0, i);
    repeat (10) idle(0);
    // R7/R8: store and correctly predicted branch
    al(1, 0, 0); al(2, 0, 1); al(0, 9, 0);
    wb(m_next - 2 < 0 ? m_next - 2 + N : m_next - 2, 32'h77, 1, 0);
    wb((m_next + N - 3) % N, 32'h55, 0, 0);
    wb((m_next + N - 1) % N, 32'h99, 0, 0);
    repeat (5) idle(0);
    // R9/R10/R11: mispredicted branch with younger slots in flight
    b = m_next;
    al(2, 0, 1); al(0, 6, 0); al(1, 0, 0); al(0, 7, 0);
    wb((b + 1) % N, 32'hDEAD, 0, (b + 1) % N);
    wb(b, 32'h0, 0, (b + 1) % N);
    // flush cycle: allocation request and late writeback into a younger slot
    step(1, 0, 1, 0, 1, (b + 2) % N, 32'hBEEF, 0, (b + 1) % N);
    wb((b + 3) % N, 32'h1234, 0, (b + 3) % N);
    idle((b + 3) % N);
    al(0, 12, 0); idle((b + 1) % N);
    wb((b + 1) % N, 32'h42, 0, (b + 1) % N); repeat (3) idle((b + 1) % N);
    // seeded random mix
    for (int i = 0; i < 4000; i++)
      step($urandom_range(0, 1), $urandom_range(0, 2), $urandom_range(0, 31), $urandom_range(0, 1),
           $urandom_range(0, 3) != 0, $urandom_range(0, N - 1), $urandom, $urandom_range(0, 1),
           $urandom_range(0, N - 1));
    repeat (20) idle(0);
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule